// File: doc/BRIEF.md
# Asynchronous static-memory bank controller

This block connects an on-chip request port to an external bus of asynchronous static memories or memory-mapped peripherals. The bus is split into four banks, and each bank has its own active-low chip select. Every bank holds its own timing profile, counted in clock cycles. The profile sets how long the address is set up before the chip select, how long the chip select is set up before the strobe, how long the access phase lasts, how long the chip select is held after the strobe, and how long the address is held after the chip select. A page-beat duration completes the profile. Each bank also has a bus width of 8 or 16 bits and a single-beat or four-beat page mode.

A client places one transaction on the request port: bank, byte offset, direction and write data. The controller runs the external strobe sequence and then pulses an acknowledge. Read data is valid on the acknowledge cycle. Bank profiles are loaded through a one-cycle configuration write. A profile loaded during an access takes effect from the next access, because each access works from a copy of its bank's profile taken when the request is accepted.

Top module: `async_bank_ctrl`

## Requirements
- R1: While reset is active and after it is released with no request, all four chip selects, the read strobe and the write strobe are high, and the data-output enable and the acknowledge are low.
- R2: During an access, only the chip select of the requested bank goes low. At most one chip select is low in any cycle.
- R3: An access runs these phases in order. Each phase lasts its field value plus one cycle.
  1. Address only: the address-setup field.
  2. Chip select low: the chip-select-setup field.
  3. Strobe low: the access field.
  4. Page beats, page-mode reads only: each beat lasts the page-beat field plus one cycle.
  5. Chip select still low, strobe high: the chip-select-hold field.
  6. Address only: the address-hold field.

  The strobe is low only while a chip select is low.
- R4: The acknowledge is high for exactly one cycle, the cycle after the last address-hold cycle. For reads, `req_rdata` carries the data captured from `mem_dq_in` on the last cycle of each strobe phase.
- R5: A 16-bit bank drives the byte offset shifted right by one on `mem_addr`. An 8-bit bank drives the offset unchanged, returns read data with bits 15:8 zero, and drives write data with bits 15:8 zero.
- R6: After reset, every bank is 8-bit, single-beat, with all timing fields zero. An access then takes 6 cycles from the accepting edge to the acknowledge.
- R7: A page-mode read makes one full access followed by three more beats, all under one chip-select low period. The first beat uses the base address. On beat k (k = 0..3), address bits 1:0 are the base's bits 1:0 plus k, modulo 4, and the higher bits are unchanged. Beat k is returned in `req_rdata[16k+15:16k]`. Writes to a page-mode bank are single-beat, and for single accesses bits 63:16 of `req_rdata` are zero.
- R8: A write holds `mem_we_n` low for the access phase and never lowers `mem_oe_n`. It asserts `mem_dq_oe` from the cycle the chip select goes low to the last chip-select-hold cycle.
- R9: A request is accepted only when the controller is idle. A request held on the port during an access does not select its bank and does not cause a second acknowledge.
- R10: `cfg_data` bit fields are as follows:

  | Bits | Field |
  |---|---|
  | 3:0 | address setup |
  | 7:4 | chip-select setup |
  | 12:8 | access |
  | 16:13 | chip-select hold |
  | 20:17 | address hold |
  | 24:21 | page beat |
  | 25 | 16-bit width |
  | 26 | page mode |

  A write to a bank during an access to that bank changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 2 | Bank written by the configuration write |
| cfg_data | input | 27 | Bank profile (fields in R10) |
| req_valid | input | 1 | Transaction request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_offset | input | 16 | Byte offset within the bank |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 64 | Read data, one 16-bit lane per page beat |
| mem_addr | output | 16 | External address |
| mem_cs_n | output | 4 | Active-low bank chip selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 16 | Write data to the external bus |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Read data from the external bus |

## Verification
Each access works from a copy of its bank's profile taken at acceptance, and it counts phases with one shared counter. A wrong counter load or a wrong profile copy therefore shows up within the same access: the chip-select or strobe low period has the wrong length, or the acknowledge arrives at the wrong cycle. The bench measures these at the pins for every access. A wrong beat index or lane selection shows as a wrong address on the next beat and a wrong lane in `req_rdata` on the acknowledge. A wrongly decoded bank register shows as a second chip select going low in the very cycle the access reaches its chip-select phase.

// File: rtl/abc_pkg.sv
package abc_pkg;

   localparam int CNT_W      = 5;
   localparam int PAGE_BEATS = 4;

   // Field order fixes the cfg_data bit positions, LSB last.
   typedef struct packed {
      logic       page;
      logic       wide;
      logic [3:0] t_pg;
      logic [3:0] t_ah;
      logic [3:0] t_ch;
      logic [4:0] t_acc;
      logic [3:0] t_cs;
      logic [3:0] t_as;
   } bank_cfg_t;

   localparam int CFG_W = $bits(bank_cfg_t);

   typedef enum logic [2:0] {
      S_IDLE, S_ASU, S_CSU, S_ACC, S_PAGE, S_CHD, S_AHD
   } seq_state_t;

endpackage

// File: rtl/abc_cfg_regs.sv
module abc_cfg_regs
   import abc_pkg::*;
#(
   parameter int NBANK = 4,
   localparam int BANK_W = $clog2(NBANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [BANK_W-1:0] cfg_bank,
   input  logic [CFG_W-1:0]  cfg_data,
   output bank_cfg_t         cfg_all [NBANK]
);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_all[b] <= '0;
         else if (cfg_we && cfg_bank == BANK_W'(b))
            cfg_all[b] <= bank_cfg_t'(cfg_data);
      end
   end

endmodule

// File: rtl/abc_addr_map.sv
module abc_addr_map #(
   parameter int OFS_W = 16,
   parameter int DW    = 16
) (
   input  logic [OFS_W-1:0] ofs,
   input  logic             wide,
   input  logic [1:0]       beat,
   input  logic [DW-1:0]    wdat,
   input  logic [DW-1:0]    dq_in,
   output logic [OFS_W-1:0] addr,
   output logic [DW-1:0]    dq_out,
   output logic [DW-1:0]    rlane
);

   localparam int HALF = DW / 2;

   logic [OFS_W-1:0] base;
   logic [1:0]       low;

   always_comb begin
      base   = wide ? {1'b0, ofs[OFS_W-1:1]} : ofs;
      low    = base[1:0] + beat;
      addr   = {base[OFS_W-1:2], low};
      dq_out = wide ? wdat  : {{HALF{1'b0}}, wdat[HALF-1:0]};
      rlane  = wide ? dq_in : {{HALF{1'b0}}, dq_in[HALF-1:0]};
   end

endmodule

// File: rtl/abc_seq.sv
module abc_seq
   import abc_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int OFS_W = 16,
   parameter int DW    = 16,
   localparam int BANK_W = $clog2(NBANK),
   localparam int RD_W   = DW * PAGE_BEATS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bank_cfg_t         cfg_all [NBANK],
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [OFS_W-1:0]  req_offset,
   input  logic [DW-1:0]     req_wdata,
   output logic              req_ack,
   output logic [RD_W-1:0]   req_rdata,
   output logic [OFS_W-1:0]  mem_addr,
   output logic [NBANK-1:0]  mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DW-1:0]     mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DW-1:0]     mem_dq_in
);

   seq_state_t        st;
   logic [CNT_W-1:0]  cnt;
   bank_cfg_t         cur;
   logic [BANK_W-1:0] bank_q;
   logic              wr_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [DW-1:0]     wd_q;
   logic [1:0]        beat;
   logic [RD_W-1:0]   rbuf;
   logic              ack;
   logic [OFS_W-1:0]  addr_w;
   logic [DW-1:0]     rlane;
   logic              last, cap, cs_act, strobe;

   abc_addr_map #(.OFS_W(OFS_W), .DW(DW)) i_map (
      .ofs(ofs_q), .wide(cur.wide), .beat(beat), .wdat(wd_q),
      .dq_in(mem_dq_in), .addr(addr_w), .dq_out(mem_dq_out), .rlane(rlane)
   );

   assign last   = (cnt == '0);
   assign cap    = !wr_q && last && (st == S_ACC || st == S_PAGE);
   assign cs_act = (st == S_CSU) || (st == S_ACC) || (st == S_PAGE) || (st == S_CHD);
   assign strobe = (st == S_ACC) || (st == S_PAGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; cnt <= '0; cur <= '0; bank_q <= '0; wr_q <= 1'b0;
         ofs_q <= '0; wd_q <= '0; beat <= '0; rbuf <= '0; ack <= 1'b0;
      end else begin
         ack <= 1'b0;
         if (st == S_IDLE) begin
            if (req_valid) begin
               cur    <= cfg_all[req_bank];
               bank_q <= req_bank;
               wr_q   <= req_write;
               ofs_q  <= req_offset;
               wd_q   <= req_wdata;
               beat   <= '0;
               rbuf   <= '0;
               cnt    <= CNT_W'(cfg_all[req_bank].t_as);
               st     <= S_ASU;
            end
         end else if (!last) begin
            cnt <= cnt - 1'b1;
         end else begin
            unique case (st)
               S_ASU: begin st <= S_CSU; cnt <= CNT_W'(cur.t_cs); end
               S_CSU: begin st <= S_ACC; cnt <= cur.t_acc; end
               S_ACC:
                  if (cur.page && !wr_q) begin
                     st <= S_PAGE; beat <= 2'd1; cnt <= CNT_W'(cur.t_pg);
                  end else begin
                     st <= S_CHD; cnt <= CNT_W'(cur.t_ch);
                  end
               S_PAGE:
                  if (beat == 2'(PAGE_BEATS - 1)) begin
                     st <= S_CHD; cnt <= CNT_W'(cur.t_ch);
                  end else begin
                     beat <= beat + 1'b1; cnt <= CNT_W'(cur.t_pg);
                  end
               S_CHD: begin st <= S_AHD; cnt <= CNT_W'(cur.t_ah); end
               default: begin st <= S_IDLE; ack <= 1'b1; end
            endcase
         end
         if (cap)
            rbuf[int'(beat)*DW +: DW] <= rlane;
      end
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_cs
      assign mem_cs_n[b] = !(cs_act && bank_q == BANK_W'(b));
   end

   assign mem_addr  = (st == S_IDLE) ? '0 : addr_w;
   assign mem_oe_n  = !(strobe && !wr_q);
   assign mem_we_n  = !(st == S_ACC && wr_q);
   assign mem_dq_oe = wr_q && cs_act;
   assign req_ack   = ack;
   assign req_rdata = rbuf;

   // R2
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_cs_n));
   // R3
   strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1));
   // R8
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));
   // R8
   dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (mem_cs_n != '1 && mem_oe_n));
   // R4
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);
   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE && st != S_AHD) |=> ($stable(bank_q) && $stable(ofs_q)));

endmodule

// File: rtl/async_bank_ctrl.sv
module async_bank_ctrl
   import abc_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int OFS_W = 16,
   parameter int DW    = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [$clog2(NBANK)-1:0] cfg_bank,
   input  logic [CFG_W-1:0]         cfg_data,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [$clog2(NBANK)-1:0] req_bank,
   input  logic [OFS_W-1:0]         req_offset,
   input  logic [DW-1:0]            req_wdata,
   output logic                     req_ack,
   output logic [DW*PAGE_BEATS-1:0] req_rdata,
   output logic [OFS_W-1:0]         mem_addr,
   output logic [NBANK-1:0]         mem_cs_n,
   output logic                     mem_oe_n,
   output logic                     mem_we_n,
   output logic [DW-1:0]            mem_dq_out,
   output logic                     mem_dq_oe,
   input  logic [DW-1:0]            mem_dq_in
);

   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("NBANK must be a power of two, at least 2");
   end
   if (DW != 16) begin : g_bad_dw
      $error("DW must be 16: banks are 8 or 16 bits wide");
   end
   if (OFS_W < 3) begin : g_bad_ofs
      $error("OFS_W must leave room for the page beat bits");
   end

   bank_cfg_t cfg_all [NBANK];

   abc_cfg_regs #(.NBANK(NBANK)) i_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
      .cfg_data(cfg_data), .cfg_all(cfg_all)
   );

   abc_seq #(.NBANK(NBANK), .OFS_W(OFS_W), .DW(DW)) i_seq (
      .clk(clk), .rst_n(rst_n), .cfg_all(cfg_all),
      .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
      .req_offset(req_offset), .req_wdata(req_wdata),
      .req_ack(req_ack), .req_rdata(req_rdata),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

endmodule

// File: tb/test_async_bank_ctrl.sv
`timescale 1ns/1ps
module test_async_bank_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_bank = '0;
   logic [26:0] cfg_data = '0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_bank = '0;
   logic [15:0] req_offset = '0, req_wdata = '0;
   logic        req_ack;
   logic [63:0] req_rdata;
   logic [15:0] mem_addr, mem_dq_out, mem_dq_in;
   logic [3:0]  mem_cs_n;
   logic        mem_oe_n, mem_we_n, mem_dq_oe;

   int checks = 0;
   int errors = 0;
   logic [26:0] shadow [4];

   always #2 clk = ~clk;

   async_bank_ctrl i_async_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
      .cfg_data(cfg_data), .req_valid(req_valid), .req_write(req_write),
      .req_bank(req_bank), .req_offset(req_offset), .req_wdata(req_wdata),
      .req_ack(req_ack), .req_rdata(req_rdata), .mem_addr(mem_addr),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   function automatic logic [15:0] memf(input logic [15:0] a);
      return {a[7:0] ^ 8'h3C, a[7:0] + 8'h11};
   endfunction

   always_comb mem_dq_in = memf(mem_addr);

   // fields: page, wide, pg, ah, ch, acc, cs, as
   typedef struct packed {
      logic [1:0]  bank;
      logic [26:0] cfg;
      logic        wr;
      logic [15:0] ofs;
      logic [15:0] wd;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{2'd0, {1'b0,1'b0,4'd0,4'd1,4'd2,5'd3,4'd1,4'd2},   1'b0, 16'h0013, 16'h0000},
      '{2'd1, {1'b0,1'b1,4'd0,4'd0,4'd0,5'd0,4'd0,4'd0},   1'b0, 16'h0246, 16'h0000},
      '{2'd2, {1'b1,1'b1,4'd2,4'd1,4'd1,5'd4,4'd2,4'd1},   1'b0, 16'h00AE, 16'h0000},
      '{2'd3, {1'b0,1'b0,4'd0,4'd2,4'd1,5'd2,4'd3,4'd0},   1'b1, 16'h00F1, 16'hBEEF},
      '{2'd2, {1'b1,1'b1,4'd2,4'd1,4'd1,5'd4,4'd2,4'd1},   1'b1, 16'h0010, 16'h1234},
      '{2'd1, {1'b0,1'b1,4'd15,4'd15,4'd15,5'd31,4'd15,4'd15}, 1'b0, 16'hFFFE, 16'h0000},
      '{2'd3, {1'b1,1'b0,4'd0,4'd0,4'd0,5'd1,4'd0,4'd0},   1'b0, 16'h0003, 16'h0000}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [1:0] b, input logic [26:0] c);
      @(negedge clk);
      cfg_we = 1'b1; cfg_bank = b; cfg_data = c;
      shadow[b] = c;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_access(input logic [1:0] b, input logic wr, input logic [15:0] ofs,
                            input logic [15:0] wd, input bit stray, input bit midcfg,
                            input logic [26:0] newcfg);
      logic [26:0] c;
      int ta, tc, tacc, tch, tah, tp, pbeats, busy_e, cs_e, stb_e;
      int n, cs_n_cnt, stb, wrong_cs, wrong_stb, dqoe;
      logic [15:0] base, last_dq, last_ad, v, a;
      logic [63:0] exp;
      c = shadow[b];
      ta = int'(c[3:0]); tc = int'(c[7:4]); tacc = int'(c[12:8]);
      tch = int'(c[16:13]); tah = int'(c[20:17]); tp = int'(c[24:21]);
      pbeats = (c[26] && !wr) ? 3 : 0;
      busy_e = ta + tc + tacc + tch + tah + 5 + pbeats * (tp + 1);
      cs_e   = tc + tacc + tch + 3 + pbeats * (tp + 1);
      stb_e  = tacc + 1 + pbeats * (tp + 1);
      base   = c[25] ? {1'b0, ofs[15:1]} : ofs;
      n = 0; cs_n_cnt = 0; stb = 0; wrong_cs = 0; wrong_stb = 0; dqoe = 0;
      last_dq = '0; last_ad = '0;
      @(negedge clk);
      req_valid = 1'b1; req_bank = b; req_write = wr; req_offset = ofs; req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      if (stray) req_bank = b ^ 2'd1;
      else req_valid = 1'b0;
      while (req_ack !== 1'b1 && n < 2000) begin
         n++;
         if (mem_cs_n[b] === 1'b0) cs_n_cnt++;
         if ((mem_cs_n | (4'b1 << b)) !== 4'hF) wrong_cs++;
         if ((wr ? mem_we_n : mem_oe_n) === 1'b0) stb++;
         if ((wr ? mem_oe_n : mem_we_n) === 1'b0) wrong_stb++;
         if (mem_dq_oe === 1'b1) dqoe++;
         if (mem_we_n === 1'b0) begin last_dq = mem_dq_out; last_ad = mem_addr; end
         if (midcfg && n == 2) begin
            cfg_we = 1'b1; cfg_bank = b; cfg_data = newcfg; shadow[b] = newcfg;
         end else cfg_we = 1'b0;
         @(negedge clk);
      end
      cfg_we = 1'b0;
      req_valid = 1'b0;
      chk("R3 busy cycles", 64'(n), 64'(busy_e));
      chk("R3 cs low cycles", 64'(cs_n_cnt), 64'(cs_e));
      chk("R3 strobe cycles", 64'(stb), 64'(stb_e));
      chk("R2 other cs low", 64'(wrong_cs + wrong_stb), 64'd0);
      if (wr) begin
         chk("R8 dq_oe cycles", 64'(dqoe), 64'(cs_e));
         chk("R5 write data lane", 64'(last_dq), 64'(c[25] ? wd : {8'h00, wd[7:0]}));
         chk("R5 write address", 64'(last_ad), 64'(base));
         chk("R7 write rdata zero", req_rdata, 64'd0);
      end else begin
         exp = '0;
         for (int k = 0; k <= pbeats; k++) begin
            a = {base[15:2], 2'(base[1:0] + 2'(k))};
            v = memf(a);
            exp[k*16 +: 16] = c[25] ? v : {8'h00, v[7:0]};
         end
         chk("R4 R5 R7 read data", req_rdata, exp);
      end
      @(negedge clk);
      chk("R4 ack single pulse", 64'(req_ack), 64'd0);
      chk("R9 idle after ack", 64'(mem_cs_n), 64'hF);
   endtask

   initial begin
      for (int b = 0; b < 4; b++) shadow[b] = '0;
      repeat (3) @(negedge clk);
      chk("R1 cs_n in reset", 64'(mem_cs_n), 64'hF);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 cs_n idle", 64'(mem_cs_n), 64'hF);
      chk("R1 strobes idle", 64'({mem_oe_n, mem_we_n}), 64'h3);
      chk("R1 ack and dq_oe idle", 64'({req_ack, mem_dq_oe}), 64'h0);
      // R6: defaults, 6-cycle access, 8-bit, unshifted address
      do_access(2'd0, 1'b0, 16'h0105, 16'h0, 1'b0, 1'b0, '0);
      // R6: default write, upper lane zero
      do_access(2'd2, 1'b1, 16'h0007, 16'hA55A, 1'b0, 1'b0, '0);
      for (int i = 0; i < 7; i++) begin
         write_cfg(VECS[i].bank, VECS[i].cfg);
         do_access(VECS[i].bank, VECS[i].wr, VECS[i].ofs, VECS[i].wd, 1'b0, 1'b0, '0);
      end
      // R9: request held during an access
      do_access(2'd0, 1'b0, 16'h0021, 16'h0, 1'b1, 1'b0, '0);
      // R10: profile written mid-access applies to the next access only
      do_access(2'd3, 1'b0, 16'h0040, 16'h0, 1'b0, 1'b1,
                {1'b0,1'b1,4'd0,4'd3,4'd2,5'd5,4'd1,4'd4});
      do_access(2'd3, 1'b0, 16'h0040, 16'h0, 1'b0, 1'b0, '0);
      do_access(2'd3, 1'b1, 16'h0042, 16'hC3A7, 1'b0, 1'b0, '0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule